// File: doc/BRIEF.md
# Byte-Masked Synchronous RAM Port

This block is a single-clock RAM with one write port and one read port. Each word is divided into lanes, and every lane has its own enable bit. A write changes only the lanes whose enable bit is set. The other lanes keep the value they already held. The word width is a parameter with four legal settings: 16, 18, 32 or 36 bits. At 18 and 36 bits each lane is nine bits wide, so the extra bit is written together with its byte. At 16 and 32 bits each lane is a plain 8-bit byte. The block never generates or checks parity on the extra bit; it stores and returns that bit like any other data bit.

A single clock enable gates the whole block. When it is low, nothing is written, nothing is read and the output register holds its value. Read and write have separate enables, so either operation can be suppressed on its own. Read data is registered. A read on the same edge as a write to the same address returns the contents from before the write. A synchronous reset clears only the read-data register and leaves the stored words as they are. The storage is written so that FPGA block RAM can be inferred, with one narrow array per lane.

Top module: `bmr_ram_port`

## Requirements
- R1: While `ce` is low at a rising edge, no write takes place, no read takes place, and `rd_data` keeps its value.
- R2: When `ce` and `re` are both high at an edge, `rd_data` shows the word at `rd_addr` one cycle later. While `re` is low, `rd_data` holds its value.
- R3: A write happens only when `ce` and `we` are both high. With `we` low, the stored contents do not change.
- R4: In a write, only lanes whose `be` bit is high (active high) are updated. Bit 0 of `be` selects the lowest lane, and each higher bit selects the next higher lane. Lanes that are not selected keep their previous contents.
- R5: Every combination of `be` bits is legal. That includes the combination with all bits low, where the write changes nothing.
- R6: Lane layout depends on `WORD_W`. At 16 bits there are two 8-bit lanes, and at 32 bits there are four. At 18 bits there are two 9-bit lanes (8..0 and 17..9). At 36 bits there are four 9-bit lanes (8..0, 17..9, 26..18 and 35..27). `be` is 2 bits wide for 16 and 18, and 4 bits wide for 32 and 36.
- R7: In the 9-bit lane modes, the top bit of each lane is stored and returned unchanged, with no parity computed or checked.
- R8: With `be` held at all ones, the block behaves as a plain RAM whose writes depend only on `we`.
- R9: A read and a write to the same address on the same edge return the old stored word. A later read returns the new word.
- R10: A synchronous reset (`rst` high at an edge) clears `rd_data` to zero. It does not alter the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read-data register |
| ce | input | 1 | Clock enable for the whole block |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| be | input | LANES | Lane write enables, bit 0 selects the lowest lane |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | WORD_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | WORD_W | Registered read data |

## Verification
The assertions check three rules on every cycle:
- the output holds while the clock enable or the read enable is low;
- the output clears after a reset;
- two back-to-back reads of one address, with no write between them, return the same word.

Lane masking, lane order, the carried ninth bit, read-before-write ordering and the survival of stored data across reset depend on the contents of the array. Only the bench's scenarios can show these. The bench compares the output against a behavioural model on every clock, and adds directed checks against hand-computed words.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // Lanes are nine bits wide when the word width is a multiple of nine.
  function automatic int lane_width(input int word_w);
    return (word_w % 9 == 0) ? 9 : 8;
  endfunction

  function automatic int lane_count(input int word_w);
    return word_w / lane_width(word_w);
  endfunction
endpackage

// File: rtl/bmr_strobe.sv
module bmr_strobe #(
  parameter int LANES = 4
) (
  input  logic             ce,
  input  logic             we,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] lane_wr
);
  // One write strobe per lane, gated by the block enables.
  for (genvar g = 0; g < LANES; g++) begin : g_strobe
    assign lane_wr[g] = ce & we & be[g];
  end
endmodule

// File: rtl/bmr_lane_store.sv
module bmr_lane_store #(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data
);
  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_q;

  // Write process: no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read. The nonblocking write above makes a same-edge
  // read return the old word.
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bmr_ram_port.sv
module bmr_ram_port #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 4,
  localparam int LANE_W = bmr_pkg::lane_width(WORD_W),
  localparam int LANES  = bmr_pkg::lane_count(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic              re,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [LANES-1:0] lane_wr;
  logic             rd_go;

  assign rd_go = ce & re;

  bmr_strobe #(.LANES(LANES)) u_strobe (
    .ce      (ce),
    .we      (we),
    .be      (be),
    .lane_wr (lane_wr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bmr_lane_store #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (lane_wr[l]),
      .wr_addr (wr_addr),
      .wr_data (wr_data[l*LANE_W +: LANE_W]),
      .rd_en   (rd_go),
      .rd_addr (rd_addr),
      .rd_data (rd_data[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/bmr_ram_port_chk.sv
module bmr_ram_port_chk #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 4,
  localparam int LANES = bmr_pkg::lane_count(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              we,
  input logic              re,
  input logic [LANES-1:0]  be,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(rd_data)); // R1

  AST_RE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ce && !re) |=> $stable(rd_data)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0)); // R10

  AST_NO_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (armed && ce && re && $past(ce && re) && rd_addr == $past(rd_addr)
     && !$past(ce && we && (|be)))
    |=> (rd_data == $past(rd_data))); // R3
endmodule

bind bmr_ram_port bmr_ram_port_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .we      (we),
  .re      (re),
  .be      (be),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/bmr_ram_port_test.sv
module bmr_ram_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 36;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce = 1'b0, we = 1'b0, re = 1'b0;
  logic [LANES-1:0]  be = '0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [WORD_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R10";

  logic [WORD_W-1:0] model [1<<ADDR_W];
  logic [WORD_W-1:0] exp_rd = '0;

  bmr_ram_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .re(re), .be(be),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: read first, then apply lane writes.
  always @(posedge clk) begin
    if (rst) exp_rd = '0;
    else if (ce) begin
      if (re) exp_rd = model[rd_addr];
      if (we)
        for (int l = 0; l < LANES; l++)
          if (be[l]) model[wr_addr][l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
    end
  end

  task automatic chk(input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) chk(cur_req, rd_data, exp_rd);

  task automatic step(input logic c, input logic w, input logic r,
                      input logic [LANES-1:0] b, input logic [ADDR_W-1:0] wa,
                      input logic [WORD_W-1:0] wd, input logic [ADDR_W-1:0] ra);
    ce = c; we = w; re = r; be = b; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    chk("R10", rd_data, '0);                               // reset state
    rst = 1'b0;

    // R8: full-word writes with all-ones enable, then read back
    cur_req = "R8";
    for (int a = 0; a < 16; a++) step(1, 1, 0, 4'hF, a[3:0], {a[3:0], 32'hA5A5_0000 + a}, 0);
    for (int a = 0; a < 16; a++) step(1, 0, 1, 4'hF, 0, 0, a[3:0]);
    step(1, 0, 1, 4'hF, 0, 0, 4'd7);
    chk("R8", rd_data, {4'd7, 32'hA5A5_0007});

    // R4/R6: lanes 0 and 2 (bits 8..0 and 26..18) cleared, others kept
    cur_req = "R4";
    step(1, 1, 0, 4'hF, 4'd2, 36'hF_FFFF_FFFF, 0);
    step(1, 1, 0, 4'b0101, 4'd2, 36'h0, 0);
    step(1, 0, 1, 4'h0, 0, 0, 4'd2);
    chk("R6", rd_data, 36'hFF803FE00);
    step(1, 1, 0, 4'b1000, 4'd2, 36'h0, 0);                // only top lane 35..27
    step(1, 0, 1, 4'h0, 0, 0, 4'd2);
    chk("R4", rd_data, 36'h00003FE00);

    // R7: ninth bit of each lane is plain storage
    cur_req = "R7";
    step(1, 1, 0, 4'hF, 4'd3, 36'h0, 0);
    step(1, 1, 0, 4'b0001, 4'd3, 36'hF_FFFF_F100, 0);
    step(1, 1, 0, 4'b0100, 4'd3, 36'h0_0400_0000, 0);
    step(1, 0, 1, 4'h0, 0, 0, 4'd3);
    chk("R7", rd_data, 36'h0_0400_0100);

    // R5: every enable combination on one address
    cur_req = "R5";
    for (int m = 0; m < 16; m++) begin
      step(1, 1, 0, m[3:0], 4'd4, {9'(m), 9'(m + 1), 9'(m + 2), 9'(m + 3)}, 0);
      step(1, 0, 1, 4'h0, 0, 0, 4'd4);
    end
    step(1, 1, 0, 4'hF, 4'd4, 36'h1_1111_1111, 0);
    step(1, 1, 0, 4'h0, 4'd4, 36'h0, 0);                   // no lane selected
    step(1, 0, 1, 4'h0, 0, 0, 4'd4);
    chk("R5", rd_data, 36'h1_1111_1111);

    // R3: write enable low leaves contents alone
    cur_req = "R3";
    step(1, 0, 0, 4'hF, 4'd4, 36'h0, 0);
    step(1, 0, 1, 4'hF, 0, 0, 4'd4);
    chk("R3", rd_data, 36'h1_1111_1111);

    // R1: clock enable low blocks write and read
    cur_req = "R1";
    step(1, 0, 1, 4'h0, 0, 0, 4'd7);
    step(0, 1, 1, 4'hF, 4'd7, 36'h0, 4'd4);
    chk("R1", rd_data, {4'd7, 32'hA5A5_0007});
    step(1, 0, 1, 4'h0, 0, 0, 4'd7);
    chk("R1", rd_data, {4'd7, 32'hA5A5_0007});

    // R2: read enable low holds output
    cur_req = "R2";
    step(1, 0, 0, 4'h0, 0, 0, 4'd2);
    chk("R2", rd_data, {4'd7, 32'hA5A5_0007});
    step(1, 0, 1, 4'h0, 0, 0, 4'd2);
    chk("R2", rd_data, 36'h00003FE00);

    // R9: same-edge read and write of one address
    cur_req = "R9";
    step(1, 1, 0, 4'hF, 4'd5, 36'h0_AAAA_AAAA, 0);
    step(1, 1, 1, 4'hF, 4'd5, 36'h1_2345_6789, 4'd5);
    chk("R9", rd_data, 36'h0_AAAA_AAAA);
    step(1, 0, 1, 4'h0, 0, 0, 4'd5);
    chk("R9", rd_data, 36'h1_2345_6789);

    // R10: reset clears output, stored words survive
    cur_req = "R10";
    rst = 1'b1;
    step(1, 0, 1, 4'h0, 0, 0, 4'd5);
    chk("R10", rd_data, '0);
    rst = 1'b0;
    step(1, 0, 1, 4'h0, 0, 0, 4'd5);
    chk("R10", rd_data, 36'h1_2345_6789);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule